// File: doc/BRIEF.md
# Flash Command and Status Sequencer

This block is the control core of a byte-wide NOR-style flash device split into four equal sectors. A host drives chip enable, write enable and output enable (all active low), an address and an 8-bit data bus. These strobes are sampled in the block's clock domain. A write is taken on a rising write enable while chip enable is low. A read is taken on a falling output enable while chip enable is low. Unlocked command sequences start embedded operations on a behavioural array that is held at all FFh after reset. The supported operations are byte program, erase of a chosen set of sectors, and erase of the whole chip. While an operation runs, reads return a toggle status byte instead of array data.

The command decoder has the states D_IDLE, D_UNL1, D_UNL2, D_PDATA, D_ERS1, D_ERS2 and D_ERS3. Each correct unlock or erase-prefix cycle moves it one state forward. A wrong cycle, or F0h, returns it to D_IDLE. The operation engine starts in E_IDLE, which handles plain array reads.
- A program command moves E_IDLE to E_PROG, and E_PROG returns to E_IDLE when its pulse ends.
- A sector command moves E_IDLE to E_WIN, the window that collects sectors. A chip command moves E_IDLE straight to E_PRE.
- The erase then runs E_PRE (pre-program to 00h), E_PULSE (timed pulse), E_CLR (write FFh) and E_VFY (read back). A byte that fails E_VFY sends the engine back to E_PULSE. When E_VFY passes, the engine returns to E_IDLE.
- A suspend command moves E_PRE, E_PULSE or E_CLR to E_SUSP. A resume command moves E_SUSP back to the saved phase. A program command moves E_SUSP to E_SPROG, and E_SPROG returns to E_SUSP.

Each pulse length and the collection window are parameters, so they can be scaled down for simulation.

Top module: `flash_seq`

## Requirements
- R1: After reset every array byte reads FFh, and dout holds FFh until the first read strobe.
- R2: A command needs AAh written to address 555h, then 55h written to 2AAh, then a command byte. Only the low min(ADDR_W,11) address bits are compared. A wrong cycle, or F0h outside program data, drops the prefix, and the writes that follow do not change the array.
- R3: Third byte A0h, then one address/data write, programs a byte. The stored value becomes the old byte ANDed with the new data, and it reads back once PROG_CYC cycles have passed.
- R4: While an operation runs, a read returns a status byte in which only bit 6 and bit 2 can be 1. Bit 6 inverts on every status read, and its first status read after reset gives 1.
- R5: On a status read, bit 2 inverts only if the read address lies in a sector marked for erase. Otherwise bit 2 keeps its previous value.
- R6: The sequence 80h, then the unlock prefix, then 30h at a sector address marks that sector and opens a window of WIN_CYC cycles. In that window, each single 30h write marks the addressed sector and restarts the window. When the window expires, the marked sectors are erased to FFh and the other sectors are left unchanged.
- R7: The same prefix followed by 10h at 555h erases every sector.
- R8: A sector whose prot bit is set is never written. A program aimed at it is ignored, and erase commands leave it out of the marked set.
- R9: The unlock prefix followed by B0h pauses an erase during its pre-program, pulse or clear phase. While paused, reads of unmarked sectors return array data, and reads of marked sectors return the status byte.
- R10: While an erase is paused, a program aimed at an unmarked sector runs and then the erase returns to the paused state. A program aimed at a marked sector is ignored, and the block stays paused.
- R11: The unlock prefix followed by 30h resumes a paused erase, which then completes.
- R12: dout changes only on a read strobe. Writes made while chip enable is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low; a read is taken on its falling edge |
| addr | input | ADDR_W | Byte address; the top SEC_W bits select the sector |
| din | input | 8 | Write data / command byte |
| prot | input | 2**SEC_W | Per-sector protection flags |
| dout | output | 8 | Read data or status byte |

## Verification
The bench builds the block with ADDR_W=6, giving 16-byte sectors, with PROG_CYC=12, ERASE_CYC=20 and WIN_CYC=16. With these values a full erase finishes in a few hundred cycles. That lets one run cover every engine state, including resume after a suspend. The window is wide enough for two extra sector writes to land inside it, and a program lasts long enough for a read to catch it running. A behavioural model keeps the expected byte after each read, including toggle history and sector marks, and compares it with dout on every clock.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        E_IDLE, E_WIN, E_PRE, E_PULSE, E_CLR, E_VFY, E_SUSP, E_PROG, E_SPROG
    } eng_state_t;

    typedef enum logic [2:0] {
        D_IDLE, D_UNL1, D_UNL2, D_PDATA, D_ERS1, D_ERS2, D_ERS3
    } dec_state_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_PROG, CMD_CHIP, CMD_SECT, CMD_SUSP, CMD_RES
    } cmd_t;

    localparam logic [10:0] UNLOCK_ADR_A = 11'h555;
    localparam logic [10:0] UNLOCK_ADR_B = 11'h2AA;
    localparam logic [7:0]  KEY_A        = 8'hAA;
    localparam logic [7:0]  KEY_B        = 8'h55;
    localparam logic [7:0]  OP_PROG      = 8'hA0;
    localparam logic [7:0]  OP_ERASE     = 8'h80;
    localparam logic [7:0]  OP_CHIP      = 8'h10;
    localparam logic [7:0]  OP_SECT      = 8'h30;
    localparam logic [7:0]  OP_SUSP      = 8'hB0;
    localparam logic [7:0]  OP_RESET     = 8'hF0;

endpackage

// File: rtl/fs_host_sync.sv
module fs_host_sync #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        din_q
);
    logic ce_q, we_q, we_p, oe_q, oe_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q   <= 1'b1;
            we_q   <= 1'b1;
            we_p   <= 1'b1;
            oe_q   <= 1'b1;
            oe_p   <= 1'b1;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            ce_q   <= ce_n;
            we_q   <= we_n;
            we_p   <= we_q;
            oe_q   <= oe_n;
            oe_p   <= oe_q;
            addr_q <= addr;
            din_q  <= din;
        end
    end

    always_comb begin
        wr_stb = we_q & ~we_p & ~ce_q;
        rd_stb = ~oe_q & oe_p & ~ce_q;
    end

endmodule

// File: rtl/fs_cmd_decode.sv
module fs_cmd_decode
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [7:0]        din_q,
    output cmd_t              cmd
);
    localparam int CMD_AW = (ADDR_W < 11) ? ADDR_W : 11;

    dec_state_t st_q, st_n;
    logic at_a, at_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= D_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        at_a = addr_q[CMD_AW-1:0] == UNLOCK_ADR_A[CMD_AW-1:0];
        at_b = addr_q[CMD_AW-1:0] == UNLOCK_ADR_B[CMD_AW-1:0];
        st_n = st_q;
        cmd  = CMD_NONE;
        if (wr_stb) begin
            st_n = D_IDLE;
            if (st_q != D_PDATA && din_q == OP_RESET) begin
                st_n = D_IDLE;
            end else begin
                unique case (st_q)
                    D_IDLE:  if (at_a && din_q == KEY_A) st_n = D_UNL1;
                    D_UNL1:  if (at_b && din_q == KEY_B) st_n = D_UNL2;
                    D_UNL2: begin
                        if (din_q == OP_PROG)       st_n = D_PDATA;
                        else if (din_q == OP_ERASE) st_n = D_ERS1;
                        else if (din_q == OP_SUSP)  cmd  = CMD_SUSP;
                        else if (din_q == OP_SECT)  cmd  = CMD_RES;
                    end
                    D_PDATA: cmd = CMD_PROG;
                    D_ERS1:  if (at_a && din_q == KEY_A) st_n = D_ERS2;
                    D_ERS2:  if (at_b && din_q == KEY_B) st_n = D_ERS3;
                    D_ERS3: begin
                        if (at_a && din_q == OP_CHIP) cmd = CMD_CHIP;
                        else if (din_q == OP_SECT)    cmd = CMD_SECT;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/fs_engine.sv
module fs_engine
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SEC_W     = 2,
    parameter int PROG_CYC  = 16,
    parameter int ERASE_CYC = 64,
    parameter int WIN_CYC   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cmd_t                  cmd,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     addr_q,
    input  logic [7:0]            din_q,
    input  logic [(1<<SEC_W)-1:0] prot,
    output logic [7:0]            rd_data,
    output logic                  busy,
    output logic                  susp,
    output logic [(1<<SEC_W)-1:0] marks
);
    localparam int SEC_N = 1 << SEC_W;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int MAX_A = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
    localparam int MAX_C = (MAX_A > PROG_CYC) ? MAX_A : PROG_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);

    logic [7:0] arr [DEPTH];

    eng_state_t        st_q, st_n, ret_q, ret_n;
    logic [SEC_N-1:0]  marks_q, marks_n, new_mark;
    logic [ADDR_W-1:0] ptr_q, ptr_n, pa_q, pa_n;
    logic [7:0]        pd_q, pd_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, pcnt_q, pcnt_n;
    logic              wr_en, ptr_mark, ptr_last;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    function automatic logic [SEC_W-1:0] sec_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SEC_W];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= E_IDLE;
            ret_q   <= E_PRE;
            marks_q <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            pcnt_q  <= '0;
            pa_q    <= '0;
            pd_q    <= '0;
        end else begin
            st_q    <= st_n;
            ret_q   <= ret_n;
            marks_q <= marks_n;
            ptr_q   <= ptr_n;
            cnt_q   <= cnt_n;
            pcnt_q  <= pcnt_n;
            pa_q    <= pa_n;
            pd_q    <= pd_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
        end else if (wr_en) begin
            arr[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        st_n     = st_q;
        ret_n    = ret_q;
        marks_n  = marks_q;
        ptr_n    = ptr_q;
        cnt_n    = cnt_q;
        pcnt_n   = pcnt_q;
        pa_n     = pa_q;
        pd_n     = pd_q;
        wr_en    = 1'b0;
        wr_addr  = ptr_q;
        wr_data  = 8'hFF;
        new_mark = (SEC_N'(1) << sec_of(addr_q)) & ~prot;
        ptr_mark = marks_q[sec_of(ptr_q)];
        ptr_last = &ptr_q;
        unique case (st_q)
            E_IDLE: begin
                if (cmd == CMD_PROG && !prot[sec_of(addr_q)]) begin
                    pa_n = addr_q; pd_n = din_q; pcnt_n = '0; st_n = E_PROG;
                end else if (cmd == CMD_SECT && new_mark != '0) begin
                    marks_n = new_mark; cnt_n = '0; st_n = E_WIN;
                end else if (cmd == CMD_CHIP && ~prot != '0) begin
                    marks_n = ~prot; ptr_n = '0; st_n = E_PRE;
                end
            end
            E_WIN: begin
                if (wr_stb && din_q == OP_SECT) begin
                    marks_n = marks_q | new_mark; cnt_n = '0;
                end else if (cnt_q == CNT_W'(WIN_CYC - 1)) begin
                    ptr_n = '0; st_n = E_PRE;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            E_PRE: begin
                if (cmd == CMD_SUSP) begin
                    ret_n = E_PRE; st_n = E_SUSP;
                end else begin
                    if (ptr_mark && arr[ptr_q] != 8'h00) begin
                        wr_en = 1'b1; wr_data = 8'h00;
                    end
                    ptr_n = ptr_q + ADDR_W'(1);
                    if (ptr_last) begin cnt_n = '0; st_n = E_PULSE; end
                end
            end
            E_PULSE: begin
                if (cmd == CMD_SUSP) begin
                    ret_n = E_PULSE; st_n = E_SUSP;
                end else if (cnt_q == CNT_W'(ERASE_CYC - 1)) begin
                    ptr_n = '0; st_n = E_CLR;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            E_CLR: begin
                if (cmd == CMD_SUSP) begin
                    ret_n = E_CLR; st_n = E_SUSP;
                end else begin
                    wr_en = ptr_mark;
                    ptr_n = ptr_q + ADDR_W'(1);
                    if (ptr_last) st_n = E_VFY;
                end
            end
            E_VFY: begin
                if (ptr_mark && arr[ptr_q] != 8'hFF) begin
                    cnt_n = '0; st_n = E_PULSE;
                end else begin
                    ptr_n = ptr_q + ADDR_W'(1);
                    if (ptr_last) begin marks_n = '0; st_n = E_IDLE; end
                end
            end
            E_SUSP: begin
                if (cmd == CMD_RES) begin
                    st_n = ret_q;
                end else if (cmd == CMD_PROG && !prot[sec_of(addr_q)]
                             && !marks_q[sec_of(addr_q)]) begin
                    pa_n = addr_q; pd_n = din_q; pcnt_n = '0; st_n = E_SPROG;
                end
            end
            E_PROG, E_SPROG: begin
                if (pcnt_q == CNT_W'(PROG_CYC - 1)) begin
                    wr_en   = 1'b1;
                    wr_addr = pa_q;
                    wr_data = arr[pa_q] & pd_q;
                    st_n    = (st_q == E_PROG) ? E_IDLE : E_SUSP;
                end else begin
                    pcnt_n = pcnt_q + CNT_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        rd_data = arr[addr_q];
        busy    = (st_q != E_IDLE) && (st_q != E_SUSP);
        susp    = (st_q == E_SUSP);
        marks   = marks_q;
    end

    p_no_prot_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !prot[sec_of(wr_addr)]);

    p_susp_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == E_SUSP) |=> $stable(marks_q));

    p_susp_prog_unmarked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == E_SPROG && wr_en) |-> !marks_q[sec_of(wr_addr)]);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SEC_W     = 2,
    parameter int PROG_CYC  = 16,
    parameter int ERASE_CYC = 64,
    parameter int WIN_CYC   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            din,
    input  logic [(1<<SEC_W)-1:0] prot,
    output logic [7:0]            dout
);
    localparam int SEC_N = 1 << SEC_W;

    logic              wr_stb, rd_stb, busy, susp, show_st, rd_marked;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        din_q, rd_data;
    logic [SEC_N-1:0]  marks;
    cmd_t              cmd;
    logic              t6_q, t2_q;

    fs_host_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .addr_q(addr_q), .din_q(din_q)
    );

    fs_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr_q(addr_q),
        .din_q(din_q), .cmd(cmd)
    );

    fs_engine #(
        .ADDR_W(ADDR_W), .SEC_W(SEC_W), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr_stb(wr_stb),
        .addr_q(addr_q), .din_q(din_q), .prot(prot), .rd_data(rd_data),
        .busy(busy), .susp(susp), .marks(marks)
    );

    always_comb begin
        rd_marked = marks[addr_q[ADDR_W-1 -: SEC_W]];
        show_st   = busy | (susp & rd_marked);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t6_q <= 1'b0;
            t2_q <= 1'b0;
            dout <= 8'hFF;
        end else if (rd_stb) begin
            if (show_st) begin
                t6_q <= ~t6_q;
                t2_q <= t2_q ^ rd_marked;
                dout <= {1'b0, ~t6_q, 3'b000, t2_q ^ rd_marked, 2'b00};
            end else begin
                dout <= rd_data;
            end
        end
    end

    p_t6_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && show_st) |=> (t6_q != $past(t6_q)));

    p_t2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rd_marked) |=> $stable(t2_q));

    p_dout_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(dout));

endmodule

// File: tb/test_flash_seq.sv
`timescale 1ns/1ps
module test_flash_seq;
    localparam int AW  = 6;
    localparam int SH  = AW - 2;
    localparam logic [AW-1:0] A555 = AW'(11'h555);
    localparam logic [AW-1:0] A2AA = AW'(11'h2AA);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, ce_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [7:0] din, dout;
    logic [3:0] prot;

    flash_seq #(.ADDR_W(AW), .SEC_W(2), .PROG_CYC(12), .ERASE_CYC(20), .WIN_CYC(16))
    i_flash_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .prot(prot), .dout(dout)
    );

    int checks = 0, fails = 0;
    logic [7:0] exp_q;
    logic chk_on = 1'b0;
    string tag = "";

    logic [7:0] m_arr [64];
    logic [3:0] m_marks;
    int m_st;
    logic t6, t2;

    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (dout !== exp_q) begin
                fails++;
                $display("FAIL %s dout=%h expected=%h", tag, dout, exp_q);
            end
        end
    end

    function automatic logic [7:0] mread(input int a);
        int s = a >> SH;
        if (m_st == 1 || (m_st == 2 && m_marks[s])) begin
            t6 = ~t6;
            if (m_marks[s]) t2 = ~t2;
            return {1'b0, t6, 3'b000, t2, 2'b00};
        end
        return m_arr[a];
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic ce = 1'b0);
        @(negedge clk);
        addr = a; din = d; ce_n = ce; we_n = 1'b0;
        idle(3);
        we_n = 1'b1;
        idle(3);
        ce_n = 1'b1;
    endtask

    task automatic unlock(input logic ce = 1'b0);
        wr(A555, 8'hAA, ce);
        wr(A2AA, 8'h55, ce);
    endtask

    task automatic prog(input int a, input logic [7:0] d, input logic ce = 1'b0);
        unlock(ce);
        wr(A555, 8'hA0, ce);
        wr(AW'(a), d, ce);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(A555, 8'h80);
        unlock();
    endtask

    task automatic rd(input int a, input string t);
        @(negedge clk);
        chk_on = 1'b0;
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
        idle(4);
        exp_q = mread(a);
        tag = t;
        chk_on = 1'b1;
        oe_n = 1'b1; ce_n = 1'b1;
        idle(2);
    endtask

    task automatic finish_run();
        chk_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired dout=%h expected=done", dout);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; din = '0; prot = 4'b0000;
        for (int i = 0; i < 64; i++) m_arr[i] = 8'hFF;
        m_marks = '0; m_st = 0; t6 = 1'b0; t2 = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        checks++;
        if (dout !== 8'hFF) begin
            fails++;
            $display("FAIL R1 reset dout=%h expected=ff", dout);
        end
        rd(5, "R1");
        rd(50, "R1");

        // program into sector 3, then protect it
        prog(50, 8'h11); idle(40); m_arr[50] = 8'h11;
        prot = 4'b1000;

        // R3 / R4: program and status while busy
        prog(5, 8'h3C); m_st = 1;
        rd(5, "R4");
        idle(40); m_st = 0; m_arr[5] = 8'h3C;
        rd(5, "R3");
        prog(5, 8'hF0); idle(40); m_arr[5] = 8'h30;
        rd(5, "R3");

        // R2: broken prefix and reset code
        wr(A555, 8'hAA); wr(A555, 8'h55); wr(A555, 8'hA0); wr(AW'(6), 8'h00);
        idle(40);
        rd(6, "R2");
        wr(A555, 8'hAA); wr(AW'(0), 8'hF0); wr(A2AA, 8'h55); wr(A555, 8'hA0);
        wr(AW'(7), 8'h00);
        idle(40);
        rd(7, "R2");

        // R8: program to a protected sector
        prog(52, 8'h00); idle(40);
        rd(52, "R8");
        rd(50, "R8");

        // R12: writes with chip enable high
        prog(8, 8'h00, 1'b1); idle(40);
        rd(8, "R12");

        // R5 / R6: sector erase with window
        prog(20, 8'h55); idle(40); m_arr[20] = 8'h55;
        prog(40, 8'h0F); idle(40); m_arr[40] = 8'h0F;
        erase_prefix();
        wr(AW'(16), 8'h30);
        wr(AW'(32), 8'h30);
        wr(AW'(48), 8'h30);
        m_st = 1; m_marks = 4'b0110;
        rd(20, "R5");
        rd(21, "R5");
        rd(5, "R5");
        idle(600);
        m_st = 0; m_marks = '0;
        for (int i = 16; i < 48; i++) m_arr[i] = 8'hFF;
        rd(20, "R6");
        rd(40, "R6");
        rd(5, "R6");
        rd(50, "R8");

        // R7: chip erase
        erase_prefix();
        wr(A555, 8'h10);
        idle(600);
        for (int i = 0; i < 48; i++) m_arr[i] = 8'hFF;
        rd(5, "R7");
        rd(50, "R8");

        // R9 .. R11: suspend, program in suspend, resume
        prog(5, 8'h12); idle(40); m_arr[5] = 8'h12;
        prog(40, 8'h34); idle(40); m_arr[40] = 8'h34;
        erase_prefix();
        wr(AW'(0), 8'h30);
        m_st = 1; m_marks = 4'b0001;
        idle(24);
        unlock();
        wr(A555, 8'hB0);
        idle(10);
        m_st = 2;
        rd(40, "R9");
        rd(5, "R9");
        prog(41, 8'h56); m_st = 1;
        idle(40); m_st = 2; m_arr[41] = 8'h56;
        rd(41, "R10");
        prog(6, 8'h00);
        rd(40, "R10");
        unlock();
        wr(A555, 8'h30);
        m_st = 1;
        idle(600);
        m_st = 0; m_marks = '0;
        for (int i = 0; i < 16; i++) m_arr[i] = 8'hFF;
        rd(5, "R11");
        rd(40, "R11");
        rd(41, "R11");

        idle(5);
        finish_run();
    end

endmodule